// File: doc/BRIEF.md
# Binary Patch Displacement Search

This block locates an 8x8 binary reference patch (one bit per pixel) inside a 22x22 binary search field. Every 8x8 window position in the field has its own exact-match comparator, which gives a 15x15 grid of candidate offsets. The comparator hits are priority-resolved and flattened into a position index. The index is then turned into a displacement vector of two 4-bit one's-complement components, packed into one byte.

A caller presents a patch and a field together with a strobe. One clock later the packed vector appears with a valid flag. The component code 1000 is reserved as "no usable result", and downstream logic discards any vector that carries it. The patch size, field size and component width are parameters. The defaults are 8, 22 and 4.

Top module: `disp_search`

## Requirements
- R1: Field bit (row, col) is `field_i[row*22+col]` and patch bit (r, c) is `patch_i[r*8+c]`. The window for offset (dx, dy) covers field rows 7+dy to 14+dy and columns 7+dx to 14+dx, so offset (0,0) sits at the field centre and each axis spans -7 to +7.
- R2: A window matches only when all 64 of its bits equal the patch. A single differing bit removes the match.
- R3: `vec_o[7:4]` holds x (dx) and `vec_o[3:0]` holds y (dy), both in one's complement. A value n of 0 or more is coded as n, and a negative value is coded as the bitwise inverse of its magnitude (for example, -6 is coded as 1001).
- R4: When no window matches, both nibbles are 1000, so `vec_o` is 8'h88.
- R5: When several windows match, the reported one is the first in row-major order: dy is the major key, dx the minor key, and the order starts at (-7,-7).
- R6: An offset of -7 on an axis is coded as 1000 in that nibble, which is the same code as "invalid".
- R7: `vld_o` equals `vld_i` delayed by one clock. `vec_o` loads only on a cycle with `vld_i` high and holds its value otherwise.
- R8: A synchronous active-high reset clears `vec_o` to 0 and `vld_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Strobe: patch and field are valid this cycle |
| patch_i | input | 64 | Reference patch, row-major |
| field_i | input | 484 | Search field, row-major |
| vld_o | output | 1 | Result valid, one clock after the strobe |
| vec_o | output | 8 | Packed displacement {x, y} |

## Verification
The in-RTL assertions check every cycle that the chosen index points at a real comparator hit and that no lower-indexed window also hit. They also check the no-hit code, the one-cycle valid delay, and that the output holds between strobes. Only the bench scenarios can show that the index maps to the correct offset and nibble coding: centre, corners, negative values, the -7 collision with the invalid code, a one-bit mismatch, and duplicate placements. Reset clearing is likewise shown only by the bench.

// File: rtl/disp_pkg.sv
package disp_pkg;

   // number of window offsets along one axis
   function automatic int span_of(input int field_w, input int patch_w);
      return field_w - patch_w + 1;
   endfunction

   // largest offset magnitude along one axis (span is odd)
   function automatic int half_of(input int field_w, input int patch_w);
      return (field_w - patch_w) / 2;
   endfunction

endpackage

// File: rtl/patch_cmp.sv
module patch_cmp #(
   parameter int PATCH = 8
) (
   input  logic [PATCH*PATCH-1:0] win_i,
   input  logic [PATCH*PATCH-1:0] patch_i,
   output logic                   hit_o
);
   localparam int NBITS = PATCH * PATCH;

   logic [NBITS-1:0] diff;

   assign diff  = win_i ^ patch_i;
   assign hit_o = ~(|diff);
endmodule

// File: rtl/hit_encoder.sv
module hit_encoder #(
   parameter int NHIT = 225,
   parameter int IDXW = 8
) (
   input  logic [NHIT-1:0] hits_i,
   output logic [IDXW-1:0] idx_o,
   output logic            any_o
);
   localparam int OHW = 1 << IDXW;

   if (OHW < NHIT) begin : g_bad_width
      $error("hit_encoder: IDXW too small for NHIT");
   end

   logic [OHW-1:0] padded;
   logic [OHW-1:0] iso;

   assign padded = OHW'(hits_i);
   // keep only the lowest set bit
   assign iso    = padded & (~padded + OHW'(1));
   assign any_o  = |padded;

   // flat encoder: each index bit is the OR of the one-hot lines whose position has it set
   for (genvar k = 0; k < IDXW; k++) begin : g_bit
      logic [OHW-1:0] sel;
      for (genvar i = 0; i < OHW; i++) begin : g_line
         if (((i >> k) & 1) == 1) begin : g_on
            assign sel[i] = iso[i];
         end else begin : g_off
            assign sel[i] = 1'b0;
         end
      end
      assign idx_o[k] = |sel;
   end
endmodule

// File: rtl/vec_pack.sv
module vec_pack #(
   parameter int SPAN  = 15,
   parameter int IDXW  = 8,
   parameter int COMPW = 4
) (
   input  logic [IDXW-1:0]    idx_i,
   input  logic               any_i,
   output logic [2*COMPW-1:0] vec_o
);
   localparam int HALF = (SPAN - 1) / 2;
   localparam logic [COMPW-1:0] INV = {1'b1, {(COMPW-1){1'b0}}};

   function automatic logic [COMPW-1:0] ones_comp(input int v);
      if (v >= 0) return COMPW'(v);
      return ~COMPW'(-v);
   endfunction

   int row_n;
   int col_n;

   always_comb begin
      row_n = int'(idx_i) / SPAN;
      col_n = int'(idx_i) % SPAN;
      if (any_i) vec_o = {ones_comp(col_n - HALF), ones_comp(row_n - HALF)};
      else       vec_o = {INV, INV};
   end
endmodule

// File: rtl/disp_search.sv
module disp_search #(
   parameter int PATCH = 8,
   parameter int FIELD = 22,
   parameter int COMPW = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     vld_i,
   input  logic [PATCH*PATCH-1:0]   patch_i,
   input  logic [FIELD*FIELD-1:0]   field_i,
   output logic                     vld_o,
   output logic [2*COMPW-1:0]       vec_o
);
   import disp_pkg::*;

   localparam int SPAN = span_of(FIELD, PATCH);
   localparam int HALF = half_of(FIELD, PATCH);
   localparam int NPOS = SPAN * SPAN;
   localparam int IDXW = $clog2(NPOS);
   localparam int OHW  = 1 << IDXW;
   localparam int VW   = 2 * COMPW;
   localparam logic [COMPW-1:0] INV = {1'b1, {(COMPW-1){1'b0}}};

   if (PATCH < 1 || PATCH > FIELD) begin : g_bad_patch
      $error("disp_search: PATCH must lie in 1..FIELD");
   end
   if ((SPAN % 2) == 0) begin : g_bad_span
      $error("disp_search: FIELD-PATCH must be even for a centred origin");
   end
   if (HALF > (1 << (COMPW-1)) - 1) begin : g_bad_compw
      $error("disp_search: COMPW too narrow for the offset range");
   end

   logic [NPOS-1:0] hits;
   logic [IDXW-1:0] idx;
   logic            any_hit;
   logic [VW-1:0]   vec_d;
   logic [VW-1:0]   vec_q;
   logic            vld_q;

   // one comparator per window position, row-major
   for (genvar gr = 0; gr < SPAN; gr++) begin : g_row
      for (genvar gc = 0; gc < SPAN; gc++) begin : g_col
         logic [PATCH*PATCH-1:0] win;
         for (genvar r = 0; r < PATCH; r++) begin : g_wrow
            assign win[r*PATCH +: PATCH] = field_i[(gr+r)*FIELD + gc +: PATCH];
         end
         patch_cmp #(.PATCH(PATCH)) u_cmp (
            .win_i   (win),
            .patch_i (patch_i),
            .hit_o   (hits[gr*SPAN + gc])
         );
      end
   end

   hit_encoder #(.NHIT(NPOS), .IDXW(IDXW)) u_enc (
      .hits_i (hits),
      .idx_o  (idx),
      .any_o  (any_hit)
   );

   vec_pack #(.SPAN(SPAN), .IDXW(IDXW), .COMPW(COMPW)) u_pack (
      .idx_i (idx),
      .any_i (any_hit),
      .vec_o (vec_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vec_q <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= vld_i;
         if (vld_i) vec_q <= vec_d;
      end
   end

   assign vec_o = vec_q;
   assign vld_o = vld_q;

   logic [OHW-1:0] hits_pad;
   assign hits_pad = OHW'(hits);

   // R5
   hit_idx_chk: assert property (@(posedge clk) disable iff (rst)
      any_hit |-> hits_pad[idx]);

   // R5
   lowest_win_chk: assert property (@(posedge clk) disable iff (rst)
      any_hit |-> ((hits_pad & ((OHW'(1) << idx) - OHW'(1))) == '0));

   // R4
   nohit_code_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_i && !any_hit) |=> (vec_o == {INV, INV}));

   // R7
   vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
      vld_i |=> vld_o);

   // R7
   vld_low_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> !vld_o);

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> $stable(vec_o));
endmodule

// File: tb/disp_search_bench.sv
module disp_search_bench;
   localparam int CLK_PERIOD = 10;
   localparam int P  = 8;
   localparam int F  = 22;
   localparam int H  = 7;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           vld_i = 1'b0;
   logic [P*P-1:0] patch_i = '0;
   logic [F*F-1:0] field_i = '0;
   logic           vld_o;
   logic [7:0]     vec_o;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] last_exp = 8'h00;
   bit         done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   disp_search u_disp_search (
      .clk(clk), .rst(rst), .vld_i(vld_i), .patch_i(patch_i),
      .field_i(field_i), .vld_o(vld_o), .vec_o(vec_o)
   );

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // R3 coding: negative n -> 15 + n (inverse of magnitude)
   function automatic logic [3:0] code(input int v);
      if (v >= 0) return 4'(v);
      return 4'(15 + v);
   endfunction

   // reference search per R1, R2, R5, R4
   function automatic logic [7:0] model(input logic [P*P-1:0] pt, input logic [F*F-1:0] fd);
      for (int dy = -H; dy <= H; dy++) begin
         for (int dx = -H; dx <= H; dx++) begin
            bit ok = 1'b1;
            for (int r = 0; r < P; r++)
               for (int c = 0; c < P; c++)
                  if (fd[(H+dy+r)*F + H+dx+c] != pt[r*P+c]) ok = 1'b0;
            if (ok) return {code(dx), code(dy)};
         end
      end
      return 8'h88;
   endfunction

   function automatic logic [F*F-1:0] place(input logic [F*F-1:0] fd, input logic [P*P-1:0] pt,
                                            input int dx, input int dy);
      logic [F*F-1:0] o = fd;
      for (int r = 0; r < P; r++)
         for (int c = 0; c < P; c++)
            o[(H+dy+r)*F + H+dx+c] = pt[r*P+c];
      return o;
   endfunction

   function automatic logic [F*F-1:0] rnd_field();
      logic [F*F-1:0] o;
      for (int i = 0; i < F*F; i++) o[i] = 1'($urandom);
      return o;
   endfunction

   // driver: one strobe, expected item pushed to the scoreboard
   task automatic send(input logic [P*P-1:0] pt, input logic [F*F-1:0] fd, input string tag);
      @(negedge clk);
      patch_i = pt;
      field_i = fd;
      vld_i   = 1'b1;
      exp_q.push_back(model(pt, fd));
      tag_q.push_back(tag);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         vld_i = 1'b0;
      end
   endtask

   // directed send with a hand-computed expectation cross-checked against the model
   task automatic send_known(input logic [P*P-1:0] pt, input logic [F*F-1:0] fd,
                             input logic [7:0] want, input string tag);
      check(model(pt, fd), want, {tag, " model"});
      send(pt, fd, tag);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #(CLK_PERIOD/4);
         if (!rst && vld_o) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_bad++;
               $display("FAIL R7: actual vld_o=1 expected vld_o=0 (no strobe pending)");
            end else begin
               logic [7:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               last_exp = e;
               check(vec_o, e, t);
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [P*P-1:0] pt;
      logic [F*F-1:0] fd;
      repeat (3) @(negedge clk);
      // R8 reset state
      check({7'b0, vld_o}, 8'h00, "R8 vld_o in reset");
      check(vec_o, 8'h00, "R8 vec_o in reset");
      rst = 1'b0;
      idle(2);
      check({7'b0, vld_o}, 8'h00, "R7 vld_o idle");

      pt = {$urandom, $urandom};
      // R1 centre
      send_known(pt, place(rnd_field(), pt, 0, 0), 8'h00, "R1 centre offset");
      idle(1);
      // R3 positive corner
      send_known(pt, place(rnd_field(), pt, 7, 7), 8'h77, "R3 offset (+7,+7)");
      // R3 negative y, back-to-back
      send_known(pt, place(rnd_field(), pt, 3, -6), 8'h39, "R3 offset (+3,-6)");
      send_known(pt, place(rnd_field(), pt, -1, 2), 8'hE2, "R3 offset (-1,+2)");
      idle(1);
      // R6 -7 collides with invalid code
      send_known(pt, place(rnd_field(), pt, -7, 4), 8'h84, "R6 offset (-7,+4)");
      idle(1);
      // R4 no match
      send_known(64'hFFFF_FFFF_FFFF_FFFF, '0, 8'h88, "R4 no match");
      idle(1);
      // R2 single differing bit
      fd = place(rnd_field(), pt, 2, -3);
      fd[(H-3+3)*F + H+2+4] = ~fd[(H-3+3)*F + H+2+4];
      send(pt, fd, "R2 one bit differs");
      idle(1);
      // R5 two placements, earlier row wins
      fd = place(place(rnd_field(), pt, 4, 1), pt, -5, -2);
      send_known(pt, fd, 8'hAD, "R5 duplicate placement");
      idle(1);
      // R5 every window matches
      send_known('0, '0, 8'h88, "R5 all windows match");
      idle(3);

      // R7 hold while strobe low
      send_known(pt, place(rnd_field(), pt, 5, -4), 8'h5B, "R7 load");
      idle(1);
      field_i = '0;
      patch_i = ~pt;
      idle(3);
      check(vec_o, last_exp, "R7 vec_o holds without strobe");
      check({7'b0, vld_o}, 8'h00, "R7 vld_o low without strobe");

      // random placements
      for (int k = 0; k < 30; k++) begin
         int dx;
         int dy;
         dx = int'($urandom_range(14)) - 7;
         dy = int'($urandom_range(14)) - 7;
         pt = {$urandom, $urandom};
         send(pt, place(rnd_field(), pt, dx, dy), "R1 random placement");
         if (k % 3 == 0) idle(1);
      end
      idle(4);
      check(8'(exp_q.size()), 8'h00, "R7 all results delivered");

      // R8 mid-run reset
      send(pt, place(rnd_field(), pt, 1, 1), "R3 before reset");
      idle(2);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      check(vec_o, 8'h00, "R8 vec_o after reset");
      check({7'b0, vld_o}, 8'h00, "R8 vld_o after reset");
      rst = 1'b0;
      idle(2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule